// File: doc/BRIEF.md
# Lane-Banked Reorder Buffer

This block keeps in-order retirement for a three-lane out-of-order core. Its storage is split into three banks, one bank per dispatch lane. Each bank has 24 rows, which gives 72 instructions in flight. One shared dispatch-cycle counter picks the row for every lane at once, so no bank can run ahead of the others. Each bank therefore needs only one allocation port, one completion port and one read port.

Every instruction is named by an 8-bit descriptor:

- bit 7 is the wrap bit;
- bits [6:2] are the dispatch cycle, 0 to 23;
- bits [1:0] are the lane.

On each accepted dispatch cycle the block allocates one row. The row marks the lanes that carry an instruction. A lane's execution unit later writes that lane's result once, using the row's cycle number. The oldest row retires as soon as every occupied lane in it has completed. Its results are read out once and then dropped.

A flush discards every entry. The retire logic of the core uses it for exceptions and mispredictions. The block also has a pure age comparator, which decides which of two descriptors was dispatched first.

Top module: `lane_rob`

## Requirements
- R1: After reset the buffer is empty (`rob_empty`=1, `rob_full`=0, `retire_valid`=0) and the next allocation is at cycle 0 with wrap bit 0.
- R2: Each accepted allocation advances `alloc_cycle` by one. After cycle 23 the next value is 0 and `alloc_wrap` toggles.
- R3: After 24 allocations with no retirement, `rob_full` is 1. An allocation request while full is ignored: `alloc_cycle` and `alloc_wrap` do not change.
- R4: A completion on lane L with cycle C stores its data in row C of bank L. A completion to a lane that was not allocated in that row is ignored, so that lane stays clear in `retire_lanes`.
- R5: The oldest row retires only when every occupied lane has completed. When it does, `retire_valid` is 1 and the following outputs describe the row: `retire_cycle`, `retire_wrap`, `retire_lanes` (bit L set for each occupied lane), and `retire_data`, where lane L is in bits [16L+15:16L]. The row is removed at the next clock edge.
- R6: A younger row whose lanes have all completed does not retire before an older row that is still incomplete.
- R7: A flush removes every entry. The buffer becomes empty with `retire_valid` low. The next allocation reuses the retire position, with its wrap bit.
- R8: When two descriptors have the same wrap bit, the one with the smaller cycle is older. If the cycles are also equal, the smaller lane index is older. Equal descriptors are not older than each other.
- R9: When two descriptors have different wrap bits, the one with the larger cycle number is older.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate one row this cycle |
| alloc_lanes | input | 3 | Lanes that carry an instruction in the new row |
| alloc_cycle | output | 5 | Cycle number of the next row to allocate |
| alloc_wrap | output | 1 | Wrap bit of the next row to allocate |
| rob_full | output | 1 | All 24 rows are occupied |
| rob_empty | output | 1 | No rows are occupied |
| cpl_valid | input | 3 | Per-lane completion strobe |
| cpl_cycle | input | 15 | Per-lane completion cycle number, lane L in bits [5L+4:5L] |
| cpl_data | input | 48 | Per-lane result, lane L in bits [16L+15:16L] |
| retire_valid | output | 1 | Oldest row is complete and retires at this edge |
| retire_cycle | output | 5 | Cycle number of the retiring row |
| retire_wrap | output | 1 | Wrap bit of the retiring row |
| retire_lanes | output | 3 | Occupied lanes of the retiring row |
| retire_data | output | 48 | Results of the retiring row |
| flush | input | 1 | Discard all entries |
| age_a | input | 8 | First descriptor to compare |
| age_b | input | 8 | Second descriptor to compare |
| age_a_older | output | 1 | `age_a` was dispatched before `age_b` |

## Verification
The age comparator is driven from a vector table. The table holds pairs that differ only in cycle, pairs that differ only in lane, identical pairs, and pairs split across a wrap. These pairs separate the effect of the cycle field, the lane tie-break and the wrap inversion.

The buffer itself gets three patterns:

- Rows with different lane occupancy, completed out of order. This separates lane masking from row ordering, and also includes a completion to an empty lane.
- A full fill past the wrap point. This shows the counter rollover, full detection and a rejected allocation.
- A flush of a full buffer, followed by a new dispatch. This shows that the pointers restart at the retire position.

// File: rtl/lane_rob_pkg.sv
// Package: lane_rob_pkg
// Geometry and descriptor layout shared by the lane-banked reorder buffer.
// Assumes the fixed 8-bit descriptor: wrap in bit 7, cycle in [6:2], lane in [1:0].
package lane_rob_pkg;
    localparam int ROB_LANES = 3;
    localparam int ROB_ROWS  = 24;
    localparam int LANE_W    = 2;
    localparam int CYC_W     = 5;
    localparam int DESC_W    = 1 + CYC_W + LANE_W;

    typedef struct packed {
        logic              wrap;
        logic [CYC_W-1:0]  cyc;
        logic [LANE_W-1:0] lane;
    } rob_desc_t;
endpackage

// File: rtl/lane_rob_ptr.sv
// Module: lane_rob_ptr
// Row pointer that counts 0..ROWS-1, returns to 0 and toggles its wrap bit on rollover.
// Assumes load has priority over inc. Used for both the allocate and the retire position.
module lane_rob_ptr #(
    parameter int ROWS  = 24,
    parameter int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             load_wrap,
    output logic [IDX_W-1:0] idx,
    output logic             wrap
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ROWS - 1);

    // Pointer state: reset, reload or step with rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            wrap <= 1'b0;
        end else if (load) begin
            idx  <= load_idx;
            wrap <= load_wrap;
        end else if (inc) begin
            if (idx == LAST) begin
                idx  <= '0;
                wrap <= ~wrap;
            end else begin
                idx  <= idx + 1'b1;
            end
        end
    end

    // After the last row, a step lands on row 0 with the wrap bit flipped.
    assert_wrap_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && idx == LAST) |=> (idx == '0 && wrap != $past(wrap)));
endmodule

// File: rtl/lane_rob_bank.sv
// Module: lane_rob_bank
// Storage for one dispatch lane: ROWS entries, each with occupied and done flags and a result.
// Assumes one allocation, one completion and one retire read per cycle. A result is written
// once and read once. The occupied flag is cleared on retire or flush.
module lane_rob_bank #(
    parameter int ROWS   = 24,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic              alloc_use,
    input  logic              cpl_en,
    input  logic [IDX_W-1:0]  cpl_idx,
    input  logic [DATA_W-1:0] cpl_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_pop,
    output logic              rd_used,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    logic [ROWS-1:0] used_q;
    logic [ROWS-1:0] done_q;
    logic [DATA_W-1:0] data_q [ROWS];

    // Flags: set on allocation and completion, cleared on retire or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            used_q <= '0;
            done_q <= '0;
        end else begin
            if (rd_pop) begin
                used_q[rd_idx] <= 1'b0;
                done_q[rd_idx] <= 1'b0;
            end
            if (alloc_en) begin
                used_q[alloc_idx] <= alloc_use;
                done_q[alloc_idx] <= 1'b0;
            end
            if (cpl_en && used_q[cpl_idx]) begin
                done_q[cpl_idx] <= 1'b1;
            end
        end
    end

    // Result storage: written once when the occupied entry completes.
    always_ff @(posedge clk) begin
        if (cpl_en && used_q[cpl_idx]) begin
            data_q[cpl_idx] <= cpl_data;
        end
    end

    // Read port for the retire row.
    always_comb begin
        rd_used = used_q[rd_idx];
        rd_done = done_q[rd_idx];
        rd_data = data_q[rd_idx];
    end

    // A result may be written only once per occupancy.
    assert_write_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_en && used_q[cpl_idx] && !flush) |-> !done_q[cpl_idx]);
    // A completion to an empty entry leaves it empty.
    assert_empty_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_en && !used_q[cpl_idx] && !(alloc_en && alloc_idx == cpl_idx))
        |=> !used_q[$past(cpl_idx)]);
endmodule

// File: rtl/lane_rob_age.sv
// Module: lane_rob_age
// Combinational age compare of two descriptors.
// Assumes both descriptors are live in the buffer at the same time, so they are less than
// one full lap apart. With different wrap bits, the larger cycle was dispatched first.
module lane_rob_age
    import lane_rob_pkg::*;
(
    input  rob_desc_t a,
    input  rob_desc_t b,
    output logic      a_older
);
    // Ordering: wrap-corrected cycle first, then lane index.
    always_comb begin
        if (a.wrap != b.wrap) begin
            a_older = (a.cyc > b.cyc);
        end else if (a.cyc != b.cyc) begin
            a_older = (a.cyc < b.cyc);
        end else begin
            a_older = (a.lane < b.lane);
        end
    end
endmodule

// File: rtl/lane_rob.sv
// Module: lane_rob
// Top of the lane-banked reorder buffer. One row (a set of lanes) is allocated per dispatch
// cycle into three lockstep banks. Each lane completes into its own bank. The oldest row
// retires when all of its occupied lanes are done. Flush discards all entries.
// Assumes the core holds back a dispatch while rob_full is set. Retirement is not
// back-pressured.
module lane_rob
    import lane_rob_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [ROB_LANES-1:0]        alloc_lanes,
    output logic [CYC_W-1:0]            alloc_cycle,
    output logic                        alloc_wrap,
    output logic                        rob_full,
    output logic                        rob_empty,
    input  logic [ROB_LANES-1:0]        cpl_valid,
    input  logic [ROB_LANES*CYC_W-1:0]  cpl_cycle,
    input  logic [ROB_LANES*DATA_W-1:0] cpl_data,
    output logic                        retire_valid,
    output logic [CYC_W-1:0]            retire_cycle,
    output logic                        retire_wrap,
    output logic [ROB_LANES-1:0]        retire_lanes,
    output logic [ROB_LANES*DATA_W-1:0] retire_data,
    input  logic                        flush,
    input  logic [DESC_W-1:0]           age_a,
    input  logic [DESC_W-1:0]           age_b,
    output logic                        age_a_older
);
    logic                 alloc_fire;
    logic [ROB_LANES-1:0] row_used;
    logic [ROB_LANES-1:0] row_done;

    // Allocation is accepted only with room and no flush.
    always_comb begin
        rob_empty  = (alloc_cycle == retire_cycle) && (alloc_wrap == retire_wrap);
        rob_full   = (alloc_cycle == retire_cycle) && (alloc_wrap != retire_wrap);
        alloc_fire = alloc_valid && !rob_full && !flush;
    end

    // Retire decision: every occupied lane of the oldest row must be done.
    always_comb begin
        retire_valid = !rob_empty && !flush && ((row_used & ~row_done) == '0);
        retire_lanes = row_used;
    end

    lane_rob_ptr #(.ROWS(ROB_ROWS), .IDX_W(CYC_W)) u_alloc_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (alloc_fire),
        .load      (flush),
        .load_idx  (retire_cycle),
        .load_wrap (retire_wrap),
        .idx       (alloc_cycle),
        .wrap      (alloc_wrap)
    );

    lane_rob_ptr #(.ROWS(ROB_ROWS), .IDX_W(CYC_W)) u_retire_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (retire_valid),
        .load      (1'b0),
        .load_idx  ('0),
        .load_wrap (1'b0),
        .idx       (retire_cycle),
        .wrap      (retire_wrap)
    );

    for (genvar l = 0; l < ROB_LANES; l++) begin : g_bank
        lane_rob_bank #(.ROWS(ROB_ROWS), .DATA_W(DATA_W), .IDX_W(CYC_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .alloc_en  (alloc_fire),
            .alloc_idx (alloc_cycle),
            .alloc_use (alloc_lanes[l]),
            .cpl_en    (cpl_valid[l]),
            .cpl_idx   (cpl_cycle[l*CYC_W +: CYC_W]),
            .cpl_data  (cpl_data[l*DATA_W +: DATA_W]),
            .rd_idx    (retire_cycle),
            .rd_pop    (retire_valid),
            .rd_used   (row_used[l]),
            .rd_done   (row_done[l]),
            .rd_data   (retire_data[l*DATA_W +: DATA_W])
        );
    end

    lane_rob_age u_age (
        .a       (rob_desc_t'(age_a)),
        .b       (rob_desc_t'(age_b)),
        .a_older (age_a_older)
    );

    // The pointers can never report full and empty together.
    assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rob_full && rob_empty));
    // A request while full does not move the allocate pointer.
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_full && alloc_valid && !flush)
        |=> (alloc_cycle == $past(alloc_cycle) && alloc_wrap == $past(alloc_wrap)));
    // Retirement steps through rows strictly in cycle order.
    assert_retire_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |=> retire_cycle ==
            (($past(retire_cycle) == CYC_W'(ROB_ROWS - 1)) ? '0 : $past(retire_cycle) + 1'b1));
    // A flush leaves nothing behind.
    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rob_empty && row_used == '0));
endmodule

// File: tb/lane_rob_tb.sv
`timescale 1ns/1ps
module lane_rob_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [2:0]  alloc_lanes = '0;
    logic [4:0]  alloc_cycle;
    logic        alloc_wrap;
    logic        rob_full;
    logic        rob_empty;
    logic [2:0]  cpl_valid = '0;
    logic [14:0] cpl_cycle = '0;
    logic [47:0] cpl_data = '0;
    logic        retire_valid;
    logic [4:0]  retire_cycle;
    logic        retire_wrap;
    logic [2:0]  retire_lanes;
    logic [47:0] retire_data;
    logic        flush = 1'b0;
    logic [7:0]  age_a = '0;
    logic [7:0]  age_b = '0;
    logic        age_a_older;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    lane_rob u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_lanes(alloc_lanes),
        .alloc_cycle(alloc_cycle), .alloc_wrap(alloc_wrap), .rob_full(rob_full),
        .rob_empty(rob_empty), .cpl_valid(cpl_valid), .cpl_cycle(cpl_cycle),
        .cpl_data(cpl_data), .retire_valid(retire_valid), .retire_cycle(retire_cycle),
        .retire_wrap(retire_wrap), .retire_lanes(retire_lanes), .retire_data(retire_data),
        .flush(flush), .age_a(age_a), .age_b(age_b), .age_a_older(age_a_older)
    );

    // Age vectors: {a, b, expected, wrap case}; descriptor = {wrap, cycle[4:0], lane[1:0]}.
    localparam int NV = 9;
    localparam logic [17:0] AGE_VEC [NV] = '{
        {1'b0,5'd3,2'd1,  1'b0,5'd5,2'd0,  1'b1, 1'b0},
        {1'b0,5'd5,2'd0,  1'b0,5'd3,2'd1,  1'b0, 1'b0},
        {1'b0,5'd7,2'd0,  1'b0,5'd7,2'd2,  1'b1, 1'b0},
        {1'b0,5'd7,2'd2,  1'b0,5'd7,2'd0,  1'b0, 1'b0},
        {1'b0,5'd7,2'd1,  1'b0,5'd7,2'd1,  1'b0, 1'b0},
        {1'b0,5'd20,2'd0, 1'b1,5'd2,2'd0,  1'b1, 1'b1},
        {1'b1,5'd2,2'd0,  1'b0,5'd20,2'd0, 1'b0, 1'b1},
        {1'b1,5'd22,2'd2, 1'b0,5'd1,2'd0,  1'b1, 1'b1},
        {1'b0,5'd1,2'd0,  1'b1,5'd22,2'd2, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [2:0] lanes);
        alloc_valid = 1'b1;
        alloc_lanes = lanes;
        tick();
        alloc_valid = 1'b0;
        alloc_lanes = '0;
        #1;
    endtask

    task automatic do_cpl(input int lane, input logic [4:0] cyc, input logic [15:0] d);
        cpl_valid[lane] = 1'b1;
        cpl_cycle[lane*5 +: 5] = cyc;
        cpl_data[lane*16 +: 16] = d;
        tick();
        cpl_valid = '0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // Age compare table (R8 same wrap, R9 across wrap)
        for (int i = 0; i < NV; i++) begin
            age_a = AGE_VEC[i][17:10];
            age_b = AGE_VEC[i][9:2];
            #1;
            chk(AGE_VEC[i][0] ? "R9 age across wrap" : "R8 age same wrap",
                64'(age_a_older), 64'(AGE_VEC[i][1]));
        end

        // Reset state, R1
        repeat (2) tick();
        rst_n = 1'b1;
        #1;
        chk("R1 empty", 64'(rob_empty), 64'd1);
        chk("R1 full", 64'(rob_full), 64'd0);
        chk("R1 retire_valid", 64'(retire_valid), 64'd0);
        chk("R1 alloc pos", 64'({alloc_wrap, alloc_cycle}), 64'd0);

        // Two rows with different lane occupancy
        do_alloc(3'b111);
        do_alloc(3'b101);
        chk("R2 alloc step", 64'({alloc_wrap, alloc_cycle}), 64'd2);
        do_cpl(0, 5'd1, 16'hAAAA);
        do_cpl(2, 5'd1, 16'hCCCC);
        do_cpl(1, 5'd1, 16'h5555);                 // lane 1 empty in row 1: ignored (R4)
        chk("R6 younger row waits", 64'(retire_valid), 64'd0);
        do_cpl(0, 5'd0, 16'h1111);
        do_cpl(1, 5'd0, 16'h2222);
        chk("R5 partial row held", 64'(retire_valid), 64'd0);
        do_cpl(2, 5'd0, 16'h3333);
        chk("R5 row0 retires", 64'(retire_valid), 64'd1);
        chk("R5 row0 cycle", 64'({retire_wrap, retire_cycle}), 64'd0);
        chk("R5 row0 lanes", 64'(retire_lanes), 64'b111);
        chk("R4 row0 data", 64'(retire_data), 64'h3333_2222_1111);
        tick(); #1;
        chk("R5 row1 retires", 64'(retire_valid), 64'd1);
        chk("R5 row1 cycle", 64'(retire_cycle), 64'd1);
        chk("R4 row1 lanes skip empty", 64'(retire_lanes), 64'b101);
        chk("R4 row1 lane0", 64'(retire_data[15:0]), 64'hAAAA);
        chk("R4 row1 lane2", 64'(retire_data[47:32]), 64'hCCCC);
        tick(); #1;
        chk("R5 drained", 64'(rob_empty), 64'd1);

        // Fill past the wrap point (pointer starts at 2)
        for (int k = 0; k < 22; k++) do_alloc(3'b001);
        chk("R2 rollover", 64'({alloc_wrap, alloc_cycle}), 64'h20);
        chk("R3 not yet full", 64'(rob_full), 64'd0);
        do_alloc(3'b001);
        do_alloc(3'b001);
        chk("R3 full", 64'(rob_full), 64'd1);
        chk("R3 not empty", 64'(rob_empty), 64'd0);
        do_alloc(3'b111);
        chk("R3 alloc ignored", 64'({alloc_wrap, alloc_cycle}), 64'h22);

        // Flush a full buffer
        flush = 1'b1;
        tick();
        flush = 1'b0;
        #1;
        chk("R7 empty", 64'(rob_empty), 64'd1);
        chk("R7 not full", 64'(rob_full), 64'd0);
        chk("R7 no retire", 64'(retire_valid), 64'd0);
        chk("R7 restart pos", 64'({alloc_wrap, alloc_cycle}), 64'd2);
        do_alloc(3'b010);
        chk("R7 fresh row pending", 64'(retire_valid), 64'd0);
        do_cpl(1, 5'd2, 16'hBEEF);
        chk("R7 fresh row retires", 64'(retire_valid), 64'd1);
        chk("R7 fresh row cycle", 64'({retire_wrap, retire_cycle}), 64'd2);
        chk("R7 fresh row lanes", 64'(retire_lanes), 64'b010);
        chk("R7 fresh row data", 64'(retire_data[31:16]), 64'hBEEF);
        tick(); #1;
        chk("R7 drained", 64'(rob_empty), 64'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule